// File: doc/BRIEF.md
# Relative-Addressed Uniform Fetch Unit

This unit supplies four-lane float constants to a shader datapath. The constants sit in a 96-entry bank of 96-bit vectors, where each lane is a 24-bit float word. An instruction names a base index. For float uniform sources it may also name one of three signed offset sources: two address registers and the loop counter register. The unit turns the base and the offset into a 7-bit effective index, reads the bank, and returns the vector one cycle later.

An offset outside the signed byte window is replaced by zero. The sum wraps at 128. Effective indices above the bank (96 to 127) return a vector of four 1.0 words and do not read storage. The two address registers are loaded by a move-to-address port, and each of the two components has its own enable. The loop counter register has a port of its own. Constants are written through a single synchronous write port before execution.

Top module: `ufu_fetch`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_vld` is 0 and `rd_data` is all zeros. Both address registers and the loop counter reset to 0.
- R2: `rd_vld` is high in exactly the cycle after a cycle with `rd_en` high. `rd_data` changes only in that cycle and otherwise holds its value.
- R3: When `rd_is_float` is 0 or `rd_asel` is 0, the effective index is `rd_base` and no offset is added.
- R4: With `rd_is_float` at 1, `rd_asel` value 1 takes the offset from address register 0, value 2 from address register 1, and value 3 from the loop counter register.
- R5: A selected offset below -128 or above 127, as a signed 32-bit value, counts as zero.
- R6: The effective index is (base + offset) modulo 128. For example, with base 40, an offset of 88 reads entry 0 and an offset of -73 reads entry 95.
- R7: An effective index of 96 to 127 returns four lanes of 24'h3F0000, which is 1.0 with sign 0, biased exponent 63 and mantissa 0. Lane 0 is in bits 23:0.
- R8: `mova_en_x` loads `mova_x` into address register 0 and `mova_en_y` loads `mova_y` into address register 1. The two loads are independent and may happen in the same cycle. A read in the same cycle as a load uses the old value.
- R9: A bank write with `cw_idx` below 96 stores `cw_data` at that entry. A read in the same cycle returns the old contents. A write with `cw_idx` of 96 or more changes no entry.
- R10: `loop_we` loads `loop_val` into the loop counter register, and a read in the same cycle uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_en | input | 1 | Constant bank write strobe |
| cw_idx | input | 7 | Constant bank write index |
| cw_data | input | 96 | Constant vector to write, lane 0 in the low bits |
| mova_en_x | input | 1 | Load address register 0 |
| mova_en_y | input | 1 | Load address register 1 |
| mova_x | input | 32 | Signed value for address register 0 |
| mova_y | input | 32 | Signed value for address register 1 |
| loop_we | input | 1 | Load the loop counter register |
| loop_val | input | 32 | Signed value for the loop counter register |
| rd_en | input | 1 | Read strobe |
| rd_base | input | 7 | Base index from the instruction |
| rd_asel | input | 2 | Offset source select: 0 none, 1 reg 0, 2 reg 1, 3 loop counter |
| rd_is_float | input | 1 | Source is a float uniform |
| rd_vld | output | 1 | Read result valid |
| rd_data | output | 96 | Read result vector |

## Verification
The hardest cases to reach are the ones where the offset leaves the signed byte window or the wrapped sum lands in the unbacked range 96 to 127. Only a particular pair of register value and base produces them. The stimulus loads address register 0 with the full list of offsets around a base of 40: 0, 13, 50, 60, 74, 87, 88, 128, -40, -42, -70, -73, -127 and -129. It then reaches the edges through the other two sources with values such as 0x80000000 and 127. Loads and bank writes are also issued in the same cycle as reads, to expose any read that sees the new value too early.

// File: rtl/ufu_pkg.sv
package ufu_pkg;
    parameter int LANE_W  = 24;
    parameter int LANES   = 4;
    parameter int DEPTH   = 96;
    parameter int IDX_W   = 7;
    parameter int AREG_W  = 32;
    parameter int OFF_MIN = -128;
    parameter int OFF_MAX = 127;

    localparam int VEC_W = LANE_W * LANES;
    localparam logic [LANE_W-1:0] LANE_ONE = LANE_W'(63) << 16;

    typedef logic [VEC_W-1:0]         vec_t;
    typedef logic [IDX_W-1:0]         idx_t;
    typedef logic signed [AREG_W-1:0] areg_t;

    typedef enum logic [1:0] {
        ASEL_NONE = 2'd0,
        ASEL_REG0 = 2'd1,
        ASEL_REG1 = 2'd2,
        ASEL_LOOP = 2'd3
    } asel_e;

    typedef struct packed {
        logic  en;
        idx_t  base;
        asel_e asel;
        logic  is_float;
    } rd_req_t;

    typedef struct packed {
        areg_t r0;
        areg_t r1;
        areg_t lc;
    } aregs_t;

    function automatic vec_t one_vec();
        vec_t v;
        for (int i = 0; i < LANES; i++) begin
            v[i*LANE_W +: LANE_W] = LANE_ONE;
        end
        return v;
    endfunction

    function automatic logic in_window(areg_t v);
        return (v >= areg_t'(OFF_MIN)) && (v <= areg_t'(OFF_MAX));
    endfunction
endpackage

// File: rtl/ufu_addr_regs.sv
module ufu_addr_regs
    import ufu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_x,
    input  logic   en_y,
    input  areg_t  val_x,
    input  areg_t  val_y,
    input  logic   lc_we,
    input  areg_t  lc_val,
    output aregs_t regs
);
    aregs_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (en_x)  q.r0 <= val_x;
            if (en_y)  q.r1 <= val_y;
            if (lc_we) q.lc <= lc_val;
        end
    end

    assign regs = q;
endmodule

// File: rtl/ufu_index_calc.sv
module ufu_index_calc
    import ufu_pkg::*;
(
    input  rd_req_t req,
    input  aregs_t  regs,
    output idx_t    eff_idx,
    output logic    beyond
);
    areg_t raw_off;
    areg_t off;

    always_comb begin
        unique case (req.asel)
            ASEL_REG0: raw_off = regs.r0;
            ASEL_REG1: raw_off = regs.r1;
            ASEL_LOOP: raw_off = regs.lc;
            default:   raw_off = '0;
        endcase
        if (!req.is_float || !in_window(raw_off)) begin
            off = '0;
        end else begin
            off = raw_off;
        end
        eff_idx = req.base + off[IDX_W-1:0];
        beyond  = (int'(eff_idx) > DEPTH - 1);
    end
endmodule

// File: rtl/ufu_const_bank.sv
module ufu_const_bank
    import ufu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  idx_t widx,
    input  vec_t wdata,
    input  logic re,
    input  idx_t ridx,
    input  logic beyond,
    output logic vld,
    output vec_t data
);
    vec_t mem [DEPTH];
    logic wr_ok;

    assign wr_ok = we && (int'(widx) < DEPTH);

    always_ff @(posedge clk) begin
        if (wr_ok) mem[widx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            data <= '0;
        end else begin
            vld <= re;
            if (re) begin
                data <= beyond ? one_vec() : mem[ridx];
            end
        end
    end
endmodule

// File: rtl/ufu_fetch.sv
module ufu_fetch
    import ufu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cw_en,
    input  logic [6:0]  cw_idx,
    input  logic [95:0] cw_data,
    input  logic        mova_en_x,
    input  logic        mova_en_y,
    input  logic [31:0] mova_x,
    input  logic [31:0] mova_y,
    input  logic        loop_we,
    input  logic [31:0] loop_val,
    input  logic        rd_en,
    input  logic [6:0]  rd_base,
    input  logic [1:0]  rd_asel,
    input  logic        rd_is_float,
    output logic        rd_vld,
    output logic [95:0] rd_data
);
    rd_req_t req;
    aregs_t  regs;
    idx_t    eff_idx;
    logic    beyond;

    assign req.en       = rd_en;
    assign req.base     = rd_base;
    assign req.asel     = asel_e'(rd_asel);
    assign req.is_float = rd_is_float;

    ufu_addr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .en_x   (mova_en_x),
        .en_y   (mova_en_y),
        .val_x  (mova_x),
        .val_y  (mova_y),
        .lc_we  (loop_we),
        .lc_val (loop_val),
        .regs   (regs)
    );

    ufu_index_calc u_idx (
        .req     (req),
        .regs    (regs),
        .eff_idx (eff_idx),
        .beyond  (beyond)
    );

    ufu_const_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (cw_en),
        .widx   (cw_idx),
        .wdata  (cw_data),
        .re     (req.en),
        .ridx   (eff_idx),
        .beyond (beyond),
        .vld    (rd_vld),
        .data   (rd_data)
    );
endmodule

// File: rtl/ufu_fetch_chk.sv
module ufu_fetch_chk
    import ufu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic [6:0]  rd_base,
    input logic [1:0]  rd_asel,
    input logic        rd_is_float,
    input logic        rd_vld,
    input logic [95:0] rd_data,
    input idx_t        eff_idx,
    input aregs_t      regs
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_vld && rd_data == '0)); // R1

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rd_vld == $past(rd_en)); // R2

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R2

    AST_NO_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (!rd_is_float || rd_asel == 2'd0)) |-> eff_idx == rd_base); // R3

    AST_WINDOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_is_float && rd_asel == 2'd1 && !in_window(regs.r0))
        |-> eff_idx == rd_base); // R5

    AST_ONE_FILL: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(eff_idx) >= DEPTH) |=> rd_data == one_vec()); // R7
endmodule

bind ufu_fetch ufu_fetch_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_base     (rd_base),
    .rd_asel     (rd_asel),
    .rd_is_float (rd_is_float),
    .rd_vld      (rd_vld),
    .rd_data     (rd_data),
    .eff_idx     (eff_idx),
    .regs        (regs)
);

// File: tb/ufu_fetch_test.sv
module ufu_fetch_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cw_en;
    logic [6:0]  cw_idx;
    logic [95:0] cw_data;
    logic        mova_en_x, mova_en_y;
    logic [31:0] mova_x, mova_y;
    logic        loop_we;
    logic [31:0] loop_val;
    logic        rd_en;
    logic [6:0]  rd_base;
    logic [1:0]  rd_asel;
    logic        rd_is_float;
    logic        rd_vld;
    logic [95:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string note = "";

    logic [95:0] mb [96];
    int m0 = 0, m1 = 0, ml = 0;
    logic        e_vld  = 1'b0;
    logic [95:0] e_data = '0;
    localparam logic [95:0] ONES = {4{24'h3F0000}};

    always #2.5 clk = ~clk;

    ufu_fetch uut (.*);

    function automatic logic [95:0] pattern(int i);
        logic [95:0] v;
        for (int l = 0; l < 4; l++) v[l*24 +: 24] = 24'(i * 16 + l + 1);
        return v;
    endfunction

    always @(posedge clk) begin
        string tag;
        int sel, off, idx, sum;
        #1;
        cycles++;
        tag = "R2";
        if (rst) begin
            e_vld = 0; e_data = '0; m0 = 0; m1 = 0; ml = 0;
            tag = "R1";
        end else begin
            e_vld = rd_en;
            if (rd_en) begin
                sel = (rd_asel == 1) ? m0 : (rd_asel == 2) ? m1 : (rd_asel == 3) ? ml : 0;
                if (!rd_is_float || rd_asel == 0) begin
                    off = 0; tag = "R3";
                end else if (sel < -128 || sel > 127) begin
                    off = 0; tag = "R5";
                end else begin
                    off = sel; tag = "R4";
                end
                sum = int'(rd_base) + off;
                idx = sum & 127;
                if (idx > 95) begin
                    e_data = ONES; tag = "R7";
                end else begin
                    e_data = mb[idx];
                    if (sum != idx) tag = "R6";
                end
            end
            if (cw_en && cw_idx < 96) mb[cw_idx] = cw_data;
            if (mova_en_x) m0 = int'($signed(mova_x));
            if (mova_en_y) m1 = int'($signed(mova_y));
            if (loop_we)   ml = int'($signed(loop_val));
        end
        if (!rd_vld && !e_vld && !rst && rd_data === e_data) begin
            checks++;
        end else begin
            checks++;
            if (rd_vld !== e_vld || rd_data !== e_data) begin
                errors++;
                $display("FAIL %s %s vld=%0b/%0b data=%h expected %h",
                         tag, note, rd_vld, e_vld, rd_data, e_data);
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle();
        @(negedge clk);
        cw_en = 0; cw_idx = '0; cw_data = '0;
        mova_en_x = 0; mova_en_y = 0; mova_x = '0; mova_y = '0;
        loop_we = 0; loop_val = '0;
        rd_en = 0; rd_base = '0; rd_asel = '0; rd_is_float = 0;
    endtask

    task automatic wr(int i, logic [95:0] d);
        idle(); cw_en = 1; cw_idx = 7'(i); cw_data = d;
    endtask

    task automatic setx(int v);
        idle(); mova_en_x = 1; mova_x = 32'(v);
    endtask

    task automatic rd(int base, int asel, bit fl);
        idle(); rd_en = 1; rd_base = 7'(base); rd_asel = 2'(asel); rd_is_float = fl;
    endtask

    initial begin
        int offs [14] = '{0, 13, 50, 60, 74, 87, 88, 128, -40, -42, -70, -73, -127, -129};
        rst = 1;
        idle();
        repeat (3) idle();
        note = "R1";
        rst = 0;
        idle();
        note = "R9 load";
        for (int i = 0; i < 96; i++) wr(i, pattern(i));
        note = "R1 regs zero";
        rd(40, 1, 1); rd(40, 2, 1); rd(40, 3, 1);
        note = "R3";
        rd(7, 0, 1); rd(95, 0, 1); rd(100, 0, 1);
        note = "R2 idle hold";
        idle(); idle();
        note = "R4 R5 R6 R7 sweep";
        foreach (offs[k]) begin
            setx(offs[k]);
            rd(40, 1, 1);
            rd(40, 1, 0);
        end
        note = "R8 both";
        idle(); mova_en_x = 1; mova_x = 32'(5); mova_en_y = 1; mova_y = 32'(-3);
        rd_en = 1; rd_base = 7'(20); rd_asel = 2'd1; rd_is_float = 1;
        rd(20, 1, 1); rd(20, 2, 1);
        note = "R8 y only";
        idle(); mova_en_y = 1; mova_y = 32'h8000_0000;
        rd(20, 1, 1); rd(20, 2, 1);
        note = "R10";
        idle(); loop_we = 1; loop_val = 32'd127;
        rd_en = 1; rd_base = 7'(1); rd_asel = 2'd3; rd_is_float = 1;
        rd(1, 3, 1); rd(90, 3, 1);
        idle(); loop_we = 1; loop_val = 32'd200;
        rd(33, 3, 1);
        note = "R9 write ignored";
        wr(100, {96{1'b1}});
        rd(4, 0, 1); rd(100, 0, 1);
        note = "R9 same cycle";
        idle(); cw_en = 1; cw_idx = 7'(10); cw_data = {96{1'b1}};
        rd_en = 1; rd_base = 7'(10); rd_asel = 2'd0; rd_is_float = 1;
        rd(10, 0, 1);
        note = "R1 reset again";
        idle(); rst = 1; idle(); rst = 0;
        rd(50, 1, 1);
        idle(); idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule